// File: doc/BRIEF.md
# Remote-Control Pattern Detector

This block lets one modem close a relay at a distant modem by sending a pseudorandom bit pattern over the ordinary data link. While a local send button is held, an 8-bit linear feedback shift register produces the transmit bit stream. The feedback taps come from a runtime tap mask, so each mask value gives its own code.

On the receive side the block keeps an 8-bit history of the received bits. It predicts each new bit from that history using the same tap mask, and it counts how many predictions in a row come out correct. A long enough unbroken run raises a code-present indicator. A further hold period of correct bits then closes the relay. One wrong bit, or a long silence on the receive strobe, clears the run. Because the detector predicts from the received bits themselves, it needs no alignment with the sender's starting state.

Top module: `rc_code_unit`

## Requirements
- R1: On the first clock edge at which `send_btn` is high after being low, the generator state loads 8'h01 and no bit is emitted. At each later edge with `send_btn` and `tx_stb` both high, the new bit is the XOR of the bits of (state AND `tap_mask`). The state shifts toward its MSB with the new bit entering bit 0, and `tx_bit` takes the new bit at that same edge. Otherwise `tx_bit` holds its value.
- R2: `tx_bit` is 0 from the edge after any clock edge at which `send_btn` is low, whatever `tx_stb` does.
- R3: The first 8 receive strobes after reset only fill the history register. They are neither counted nor treated as mismatches.
- R4: Each later strobed bit is scored against the XOR of the bits of (history AND `tap_mask`). The history holds the newest received bit in bit 0 and the oldest in bit 7. A stream built with one mask is not accepted under a different mask, and a mask change takes effect at the next strobe.
- R5: A run counter counts consecutive correct bits and saturates at QUAL_BITS+HOLD_BITS. `code_rx` is high exactly when the run is at least QUAL_BITS (256 by default).
- R6: A single mismatching bit clears the run, so `code_rx` and `relay_on` are low from the edge of that strobe onward. A full new run is needed to raise them again.
- R7: `relay_on` is high exactly when the run is at least QUAL_BITS+HOLD_BITS (768 by default, a 512-bit hold after qualification).
- R8: If IDLE_CLKS consecutive clocks pass with no receive strobe, the run clears at the edge that completes that count. The default is 1024 bit times of 256 clocks each.
- R9: While reset is asserted, `tx_bit`, `code_rx` and `relay_on` are low, and the history fill restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_bit | input | 1 | Received data bit, valid with rx_stb |
| rx_stb | input | 1 | One-cycle pulse per received bit |
| tx_stb | input | 1 | One-cycle pulse per transmit bit time |
| send_btn | input | 1 | Send button level, high while pressed |
| tap_mask | input | 8 | Feedback tap mask shared by generator and detector |
| tx_bit | output | 1 | Transmitted pattern bit |
| relay_on | output | 1 | Relay drive, high when closed |
| code_rx | output | 1 | High while a qualified code is being received |

## Verification
The assertions assume that `rx_stb` and `tx_stb` are single-cycle pulses with at least one idle clock between them. They also assume that `rx_bit` and `tap_mask` are stable in any cycle where a strobe is high. The bench drives every input on the falling clock edge and holds each strobe for exactly one cycle followed by idle cycles. It changes `tap_mask` only between strobes, so each scored bit sees a single mask value.

// File: rtl/rc_code_pkg.sv
package rc_code_pkg;
  localparam int unsigned RC_W = 8;
  typedef logic [RC_W-1:0] rc_word_t;
  localparam rc_word_t RC_SEED = rc_word_t'(1);
  localparam int unsigned RC_FILL_W = $clog2(RC_W + 1);
endpackage

// File: rtl/rc_pattern_gen.sv
module rc_pattern_gen
  import rc_code_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     send_btn,
  input  logic     tx_stb,
  input  rc_word_t tap_mask,
  output logic     tx_bit
);
  logic     send_q;
  rc_word_t gen_q, gen_d;
  logic     tx_q, tx_d;
  logic     first_press;
  logic     fb;

  always_comb begin
    first_press = send_btn & ~send_q;
    fb          = ^(gen_q & tap_mask);
    gen_d       = gen_q;
    tx_d        = tx_q;
    if (first_press) begin
      gen_d = RC_SEED;
    end else if (send_btn && tx_stb) begin
      gen_d = {gen_q[RC_W-2:0], fb};
      tx_d  = fb;
    end
    if (!send_btn) tx_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      send_q <= 1'b0;
      gen_q  <= RC_SEED;
      tx_q   <= 1'b0;
    end else begin
      send_q <= send_btn;
      gen_q  <= gen_d;
      tx_q   <= tx_d;
    end
  end

  assign tx_bit = tx_q;

  AST_SEED_ON_PRESS: assert property (@(posedge clk) disable iff (!rst_n)
    (send_btn && !send_q) |=> (gen_q == RC_SEED)); // R1
  AST_TX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !send_btn |=> !tx_bit); // R2
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (send_btn && send_q && !tx_stb) |=> $stable(tx_bit)); // R1
endmodule

// File: rtl/rc_bit_scorer.sv
module rc_bit_scorer
  import rc_code_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     rx_bit,
  input  logic     rx_stb,
  input  rc_word_t tap_mask,
  output logic     hit,
  output logic     miss
);
  localparam logic [RC_FILL_W-1:0] FILL_FULL = RC_FILL_W'(RC_W);

  rc_word_t              hist_q, hist_d;
  logic [RC_FILL_W-1:0]  fill_q, fill_d;
  logic                  full;
  logic                  predicted;

  always_comb begin
    full      = (fill_q == FILL_FULL);
    predicted = ^(hist_q & tap_mask);
    hist_d    = hist_q;
    fill_d    = fill_q;
    hit       = 1'b0;
    miss      = 1'b0;
    if (rx_stb) begin
      hist_d = {hist_q[RC_W-2:0], rx_bit};
      if (!full) begin
        fill_d = fill_q + 1'b1;
      end else if (rx_bit == predicted) begin
        hit = 1'b1;
      end else begin
        miss = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      fill_q <= '0;
    end else begin
      hist_q <= hist_d;
      fill_q <= fill_d;
    end
  end

  AST_FILL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_stb && fill_q != FILL_FULL) |=> (fill_q == $past(fill_q) + 1'b1)); // R3
  AST_FILL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_q != FILL_FULL) |-> (!hit && !miss)); // R3
  AST_HIST_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
    rx_stb |=> (hist_q[0] == $past(rx_bit))); // R4
endmodule

// File: rtl/rc_run_tracker.sv
module rc_run_tracker #(
  parameter int unsigned QUAL_BITS = 256,
  parameter int unsigned HOLD_BITS = 512,
  parameter int unsigned IDLE_CLKS = 262144
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_stb,
  input  logic hit,
  input  logic miss,
  output logic code_rx,
  output logic relay_on
);
  localparam int unsigned RUN_MAX = QUAL_BITS + HOLD_BITS;
  localparam int unsigned RUN_W   = $clog2(RUN_MAX + 1);
  localparam int unsigned IDLE_W  = $clog2(IDLE_CLKS + 1);
  localparam logic [RUN_W-1:0]  MAX_V  = RUN_W'(RUN_MAX);
  localparam logic [RUN_W-1:0]  QUAL_V = RUN_W'(QUAL_BITS);
  localparam logic [IDLE_W-1:0] IDLE_V = IDLE_W'(IDLE_CLKS);

  logic [RUN_W-1:0]  run_q, run_d;
  logic [IDLE_W-1:0] idle_q, idle_d;

  always_comb begin
    idle_d = idle_q;
    run_d  = run_q;
    if (rx_stb) begin
      idle_d = '0;
    end else if (idle_q != IDLE_V) begin
      idle_d = idle_q + 1'b1;
    end
    if (miss) begin
      run_d = '0;
    end else if (hit) begin
      if (run_q != MAX_V) run_d = run_q + 1'b1;
    end else if (!rx_stb && idle_d == IDLE_V) begin
      run_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      idle_q <= '0;
    end else begin
      run_q  <= run_d;
      idle_q <= idle_d;
    end
  end

  assign code_rx  = (run_q >= QUAL_V);
  assign relay_on = (run_q == MAX_V);

  AST_RUN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && run_q != MAX_V) |=> (run_q == $past(run_q) + 1'b1)); // R5
  AST_MISS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    miss |=> (!code_rx && !relay_on)); // R6
  AST_RELAY_NEEDS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    relay_on |-> code_rx); // R7
  AST_RELAY_RISE_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(relay_on) |-> $past(hit)); // R7
  AST_IDLE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_q == IDLE_V) |-> (run_q == '0)); // R8
endmodule

// File: rtl/rc_code_unit.sv
module rc_code_unit
  import rc_code_pkg::*;
#(
  parameter int unsigned QUAL_BITS = 256,
  parameter int unsigned HOLD_BITS = 512,
  parameter int unsigned IDLE_CLKS = 262144
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_bit,
  input  logic       rx_stb,
  input  logic       tx_stb,
  input  logic       send_btn,
  input  logic [7:0] tap_mask,
  output logic       tx_bit,
  output logic       relay_on,
  output logic       code_rx
);
  logic hit;
  logic miss;

  rc_pattern_gen u_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .send_btn (send_btn),
    .tx_stb   (tx_stb),
    .tap_mask (tap_mask),
    .tx_bit   (tx_bit)
  );

  rc_bit_scorer u_scorer (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_bit   (rx_bit),
    .rx_stb   (rx_stb),
    .tap_mask (tap_mask),
    .hit      (hit),
    .miss     (miss)
  );

  rc_run_tracker #(
    .QUAL_BITS (QUAL_BITS),
    .HOLD_BITS (HOLD_BITS),
    .IDLE_CLKS (IDLE_CLKS)
  ) u_tracker (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_stb   (rx_stb),
    .hit      (hit),
    .miss     (miss),
    .code_rx  (code_rx),
    .relay_on (relay_on)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (!tx_bit && !code_rx && !relay_on)); // R9
endmodule

// File: tb/tb_rc_code_unit.sv
module tb_rc_code_unit;
  localparam int QB = 256;
  localparam int HB = 512;
  localparam int IC = 300;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx_bit, rx_stb, tx_stb, send_btn;
  logic [7:0] tap_mask;
  logic       tx_bit, relay_on, code_rx;

  int n_chk = 0;
  int n_fail = 0;
  bit cmp_en = 0;
  bit done = 0;

  // reference model state
  int m_gen, m_sendd, m_tx, m_fill, m_hist, m_run, m_idle;
  // bench pattern source
  int g_state, g_mask;

  always #5 clk = ~clk;

  rc_code_unit #(.QUAL_BITS(QB), .HOLD_BITS(HB), .IDLE_CLKS(IC)) dut (
    .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .rx_stb(rx_stb),
    .tx_stb(tx_stb), .send_btn(send_btn), .tap_mask(tap_mask),
    .tx_bit(tx_bit), .relay_on(relay_on), .code_rx(code_rx)
  );

  function automatic int par8(int v);
    int p = 0;
    for (int i = 0; i < 8; i++) p = p ^ ((v >> i) & 1);
    return p;
  endfunction

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_gen = 1; m_sendd = 0; m_tx = 0; m_fill = 0; m_hist = 0; m_run = 0; m_idle = 0;
    end else begin
      int hit, miss, fb;
      hit = 0; miss = 0;
      if (send_btn && !m_sendd) m_gen = 1;
      else if (send_btn && tx_stb) begin
        fb = par8(m_gen & int'(tap_mask));
        m_gen = ((m_gen << 1) | fb) & 255;
        m_tx = fb;
      end
      if (!send_btn) m_tx = 0;
      m_sendd = send_btn;
      if (rx_stb) begin
        if (m_fill < 8) m_fill++;
        else if (par8(m_hist & int'(tap_mask)) == int'(rx_bit)) hit = 1;
        else miss = 1;
        m_hist = ((m_hist << 1) | int'(rx_bit)) & 255;
        m_idle = 0;
      end else if (m_idle < IC) m_idle++;
      if (miss) m_run = 0;
      else if (hit) begin if (m_run < QB + HB) m_run++; end
      else if (!rx_stb && m_idle == IC) m_run = 0;
    end
  end

  always @(negedge clk) begin
    if (cmp_en && rst_n) begin
      chk("R1", tx_bit, m_tx[0]);
      chk("R5", code_rx, m_run >= QB);
      chk("R7", relay_on, m_run >= QB + HB);
    end
  end

  task automatic send_rx(input logic b);
    @(negedge clk); rx_bit = b; rx_stb = 1'b1;
    @(negedge clk); rx_stb = 1'b0;
    @(negedge clk);
  endtask

  task automatic rx_pat(input int n);
    for (int i = 0; i < n; i++) begin
      int fb;
      fb = par8(g_state & g_mask);
      g_state = ((g_state << 1) | fb) & 255;
      send_rx(fb[0]);
    end
  endtask

  task automatic tx_pulse();
    @(negedge clk); tx_stb = 1'b1;
    @(negedge clk); tx_stb = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rx_bit = 0; rx_stb = 0; tx_stb = 0; send_btn = 0; tap_mask = 8'hE1;
    repeat (3) @(negedge clk);
    chk("R9", tx_bit, 1'b0); chk("R9", code_rx, 1'b0); chk("R9", relay_on, 1'b0);
    rst_n = 1'b1;
    cmp_en = 1;
    @(negedge clk);
    chk("R9", code_rx, 1'b0);

    // generator: press, then step
    send_btn = 1'b1;
    @(negedge clk);
    tx_pulse();
    chk("R1", tx_bit, 1'b1); // seed 01 & mask E1 -> parity 1
    for (int i = 0; i < 20; i++) tx_pulse();
    send_btn = 1'b0;
    @(negedge clk);
    chk("R2", tx_bit, 1'b0);
    tx_pulse();
    chk("R2", tx_bit, 1'b0);

    // receive: fill with 8'h5A, then the pattern from that state
    g_mask = 32'hE1; g_state = 32'h5A;
    for (int i = 7; i >= 0; i--) send_rx(g_state[i]);
    chk("R3", code_rx, 1'b0);
    rx_pat(QB - 1);
    chk("R3", code_rx, 1'b0);
    rx_pat(1);
    chk("R5", code_rx, 1'b1);
    rx_pat(HB - 1);
    chk("R7", relay_on, 1'b0);
    rx_pat(1);
    chk("R7", relay_on, 1'b1);

    // single wrong bit
    begin
      int fb;
      fb = par8(g_state & g_mask);
      g_state = ((g_state << 1) | fb) & 255;
      send_rx(~fb[0]);
    end
    chk("R6", code_rx, 1'b0);
    chk("R6", relay_on, 1'b0);
    rx_pat(8 + QB);
    chk("R6", code_rx, 1'b1);

    // idle timeout
    rx_pat(HB);
    chk("R7", relay_on, 1'b1);
    repeat (IC - 2) @(negedge clk);
    chk("R8", relay_on, 1'b1);
    @(negedge clk);
    chk("R8", relay_on, 1'b0);
    chk("R8", code_rx, 1'b0);
    rx_pat(1);
    chk("R8", code_rx, 1'b0);

    // mask mismatch, then runtime mask change
    @(negedge clk); tap_mask = 8'hB8;
    rx_pat(300);
    chk("R4", code_rx, 1'b0);
    g_mask = 32'hB8;
    rx_pat(QB);
    chk("R4", code_rx, 1'b1);

    // reset mid-run
    @(negedge clk); cmp_en = 0; rst_n = 1'b0;
    #1;
    chk("R9", code_rx, 1'b0);
    chk("R9", relay_on, 1'b0);
    @(negedge clk); rst_n = 1'b1; cmp_en = 1;
    rx_pat(8);
    chk("R9", code_rx, 1'b0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule